// File: doc/BRIEF.md
# Auxiliary Timestamp Snapshot and Event Unit

This unit sits next to a free-running 64-bit time-of-day counter, which it receives as an input. It does not build that counter. It has two asynchronous auxiliary inputs, called slave and master. A rising edge on either input is synchronized and then latches the current time into a snapshot that belongs only to that input. The same edge raises a sticky event flag for that channel. A third flag goes pending once the time reaches a programmed 64-bit target. A fourth flag records a one-cycle pulse-per-second tick.

Software reads and writes the unit through a small word-addressed register port. Writing ones to the event register acknowledges the flags. The mask bits in the control register decide which flags drive the single interrupt output.

Each capture channel is a two-state machine:
- ARMED: the channel waits for an edge.
- HELD: the channel has a snapshot that has not yet been acknowledged.

It moves between the states on two transitions:
- CAPTURE takes ARMED to HELD on a synchronized rising edge and loads the snapshot.
- RELEASE takes HELD back to ARMED when software acknowledges the flag.

Top module: `aux_event_unit`

## Requirements
- R1: After reset the unit is in this state:
  - every event flag, every mask bit and every snapshot is 0;
  - the target reads 0xFFFFFFFF in both halves;
  - `irq` is 0.
- R2: An input that is high for the posedge at which it is first sampled is captured two posedges later. The snapshot holds the `sys_time` present at that later posedge. The slave channel sets event bit 2 and the master channel sets event bit 3.
- R3: While a channel's flag is set, further edges on its input leave its snapshot unchanged.
- R4: A write to the event register (offset 1) clears each flag whose bit is written 1. Bits written 0 leave their flag unchanged.
- R5: Event bit 1 (target pending) is set at every posedge where `sys_time >= target`, compared unsigned on all 64 bits. It stays set until it is acknowledged. It sets again after acknowledgement while the condition still holds.
- R6: A high `pps_tick` at a posedge sets event bit 4.
- R7: Control register (offset 0) bits 1..4 are the masks for event bits 1..4. Every other control bit reads 0. `irq` is high exactly when some event bit and its mask bit are both 1.
- R8: The register offsets are as follows:

  | Offset | Register |
  |---|---|
  | 0 | control |
  | 1 | event |
  | 2 | target low |
  | 3 | target high |
  | 4 | slave snapshot low |
  | 5 | slave snapshot high |
  | 6 | master snapshot low |
  | 7 | master snapshot high |

  Each 32-bit target half is written separately. `reg_rdata` shows the register at `reg_addr` combinationally.
- R9: A steady high level or a falling edge on an auxiliary input captures nothing and sets no flag.
- R10: An acknowledgement and a competing set in the same cycle resolve differently per flag:
  - On a capture channel, the acknowledgement wins and that cycle's edge is lost.
  - On the target flag, a true comparison wins over the acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_time | input | 64 | Current time-of-day count |
| aux_slave | input | 1 | Asynchronous auxiliary input, slave channel |
| aux_master | input | 1 | Asynchronous auxiliary input, master channel |
| pps_tick | input | 1 | One-cycle pulse-per-second strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Masked OR of the event flags |

## Verification
The assertions check several relations on every cycle:
- a synchronized edge is a single-cycle pulse;
- an edge in ARMED moves the channel to HELD with the sampled time;
- HELD keeps the snapshot frozen;
- an acknowledgement releases HELD;
- a true comparison forces the target flag on;
- the interrupt follows its masks.

Other behaviour only the bench scenarios can show. These are the exact two-posedge capture latency and the time value that lands in each half of a snapshot. They also include the lost edge when an acknowledgement lands in the capture cycle, and the equal-time boundary of the target comparison.

// File: rtl/aux_evt_pkg.sv
package aux_evt_pkg;
    localparam int TIME_W  = 64;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 3;
    localparam int N_AUX   = 2;

    // Event and mask bit positions (shared by event and control registers)
    localparam int EVB_TGT = 1;
    localparam int EVB_AUX = 2;   // slave = EVB_AUX, master = EVB_AUX + 1
    localparam int EVB_PPS = 4;
    localparam int EV_W    = 5;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_EVT    = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_TGT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_TGT_HI = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_SNAP0  = 3'd4;

    typedef enum logic {
        CH_ARMED = 1'b0,
        CH_HELD  = 1'b1
    } ch_state_e;
endpackage

// File: rtl/aux_edge_sync.sv
module aux_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], async_in};
    end

    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    // R9: an edge yields exactly one pulse, a level yields none afterwards
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/aux_capture_ch.sv
module aux_capture_ch
    import aux_evt_pkg::*;
#(
    parameter int TW = TIME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          ack,
    input  logic [TW-1:0] sys_time,
    output logic          flag,
    output logic [TW-1:0] snap
);
    ch_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_ARMED: if (rise) state_d = CH_HELD;   // CAPTURE
            CH_HELD:  if (ack)  state_d = CH_ARMED;  // RELEASE
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_ARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            snap <= '0;
        else if (state_q == CH_ARMED && rise)  snap <= sys_time;
    end

    assign flag = (state_q == CH_HELD);

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && rise) |=> (flag && snap == $past(sys_time)));
    a_r3_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> $stable(snap));
    a_r10_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ack) |=> !flag);
endmodule

// File: rtl/target_cmp.sv
module target_cmp
    import aux_evt_pkg::*;
#(
    parameter int TW = TIME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] sys_time,
    input  logic [TW-1:0] target,
    input  logic          ack,
    output logic          pending
);
    logic reached;
    assign reached = (sys_time >= target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending & ~ack) | reached;
    end

    a_r5_reached_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_time >= target) |=> pending);
    a_r4_held_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |=> pending);
endmodule

// File: rtl/aux_event_unit.sv
module aux_event_unit
    import aux_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] sys_time,
    input  logic              aux_slave,
    input  logic              aux_master,
    input  logic              pps_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    logic [N_AUX-1:0]  aux_vec;
    logic [N_AUX-1:0]  aux_rise;
    logic [N_AUX-1:0]  aux_flag;
    logic [TIME_W-1:0] aux_snap [N_AUX];

    logic [EV_W-1:0]   mask_q;
    logic [TIME_W-1:0] target_q;
    logic              pps_q;
    logic              tgt_pend;
    logic [EV_W-1:0]   evt_vec;
    logic              evt_wr;
    logic [EV_W-1:0]   ack_vec;

    assign aux_vec = {aux_master, aux_slave};
    assign evt_wr  = reg_wr && (reg_addr == OFF_EVT);
    assign ack_vec = evt_wr ? reg_wdata[EV_W-1:0] : '0;

    generate
        for (genvar c = 0; c < N_AUX; c++) begin : g_ch
            aux_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (aux_vec[c]),
                .rise     (aux_rise[c])
            );
            aux_capture_ch #(.TW(TIME_W)) u_cap (
                .clk      (clk),
                .rst_n    (rst_n),
                .rise     (aux_rise[c]),
                .ack      (ack_vec[EVB_AUX+c]),
                .sys_time (sys_time),
                .flag     (aux_flag[c]),
                .snap     (aux_snap[c])
            );
        end
    endgenerate

    target_cmp #(.TW(TIME_W)) u_tgt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_time (sys_time),
        .target   (target_q),
        .ack      (ack_vec[EVB_TGT]),
        .pending  (tgt_pend)
    );

    // Control, target and pulse-per-second registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            target_q <= '1;
            pps_q    <= 1'b0;
        end else begin
            pps_q <= (pps_q & ~ack_vec[EVB_PPS]) | pps_tick;
            if (reg_wr) begin
                case (reg_addr)
                    OFF_CTRL:   mask_q <= {reg_wdata[EV_W-1:1], 1'b0};
                    OFF_TGT_LO: target_q[REG_W-1:0] <= reg_wdata;
                    OFF_TGT_HI: target_q[TIME_W-1:REG_W] <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        evt_vec          = '0;
        evt_vec[EVB_TGT] = tgt_pend;
        evt_vec[EVB_PPS] = pps_q;
        for (int c = 0; c < N_AUX; c++) evt_vec[EVB_AUX+c] = aux_flag[c];
    end

    assign irq = |(evt_vec & mask_q);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTRL:   reg_rdata[EV_W-1:0] = mask_q;
            OFF_EVT:    reg_rdata[EV_W-1:0] = evt_vec;
            OFF_TGT_LO: reg_rdata = target_q[REG_W-1:0];
            OFF_TGT_HI: reg_rdata = target_q[TIME_W-1:REG_W];
            3'd4:       reg_rdata = aux_snap[0][REG_W-1:0];
            3'd5:       reg_rdata = aux_snap[0][TIME_W-1:REG_W];
            3'd6:       reg_rdata = aux_snap[1][REG_W-1:0];
            3'd7:       reg_rdata = aux_snap[1][TIME_W-1:REG_W];
            default:    reg_rdata = '0;
        endcase
    end

    a_r7_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
    a_r7_pps_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (pps_q && mask_q[EVB_PPS]) |-> irq);
    a_r6_pps_sets: assert property (@(posedge clk) disable iff (!rst_n)
        pps_tick |=> pps_q);
endmodule

// File: tb/aux_event_unit_tb.sv
module aux_event_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_time = '0;
    logic        aux_slave = 1'b0, aux_master = 1'b0, pps_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    aux_event_unit u_dut (
        .clk(clk), .rst_n(rst_n), .sys_time(sys_time),
        .aux_slave(aux_slave), .aux_master(aux_master), .pps_tick(pps_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Behavioural reference state
    logic [3:0]  m_mask;          // {pps, master, slave, target}
    logic        m_tgt, m_pps;
    logic [1:0]  m_flag;
    logic [63:0] m_snap [2];
    logic [63:0] m_target;
    logic [1:0]  h1, h2, h3;      // input history, 1..3 posedges back
    bit          advance = 1'b1;

    task automatic model_reset();
        m_mask = '0; m_tgt = 0; m_pps = 0; m_flag = '0;
        m_snap[0] = '0; m_snap[1] = '0; m_target = '1;
        h1 = '0; h2 = '0; h3 = '0;
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {27'd0, m_mask, 1'b0};
            3'd1: return {27'd0, m_pps, m_flag[1], m_flag[0], m_tgt, 1'b0};
            3'd2: return m_target[31:0];
            3'd3: return m_target[63:32];
            3'd4: return m_snap[0][31:0];
            3'd5: return m_snap[0][63:32];
            3'd6: return m_snap[1][31:0];
            default: return m_snap[1][63:32];
        endcase
    endfunction

    function automatic string addr_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R7";
            3'd1: return "R4";
            3'd2, 3'd3: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic model_step();
        logic [3:0] clr;
        clr = (reg_wr && reg_addr == 3'd1) ? reg_wdata[4:1] : 4'd0;
        for (int c = 0; c < 2; c++) begin
            if (m_flag[c]) begin
                if (clr[c+1]) m_flag[c] = 1'b0;
            end else if (h2[c] && !h3[c]) begin
                m_flag[c] = 1'b1;
                m_snap[c] = sys_time;
            end
        end
        m_tgt = (m_tgt & ~clr[0]) | (sys_time >= m_target);
        m_pps = (m_pps & ~clr[3]) | pps_tick;
        if (reg_wr) begin
            case (reg_addr)
                3'd0: m_mask = reg_wdata[4:1];
                3'd2: m_target[31:0] = reg_wdata;
                3'd3: m_target[63:32] = reg_wdata;
                default: ;
            endcase
        end
        h3 = h2; h2 = h1; h1 = {aux_master, aux_slave};
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        if (!rst_n) model_reset();
        else begin
            model_step();
            check(addr_tag(reg_addr), {32'd0, reg_rdata}, {32'd0, model_read(reg_addr)});
            check("R7", {63'd0, irq}, {63'd0, |({m_pps, m_flag[1], m_flag[0], m_tgt} & m_mask)});
        end
        if (advance) sys_time = sys_time + 64'd1;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        cyc();
        d = reg_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [31:0] d;
        logic [63:0] s, x, t;
        model_reset();
        repeat (3) cyc();
        rst_n = 1'b1;
        sys_time = 64'd10;

        // R1 reset state
        rreg(3'd1, d); check("R1", {32'd0, d}, 64'd0);
        rreg(3'd2, d); check("R1", {32'd0, d}, 64'hFFFF_FFFF);
        rreg(3'd3, d); check("R1", {32'd0, d}, 64'hFFFF_FFFF);
        rreg(3'd4, d); check("R1", {32'd0, d}, 64'd0);
        check("R1", {63'd0, irq}, 64'd0);

        // R5 / R8 target at startup value 1, re-asserts after ack
        wreg(3'd2, 32'd1); wreg(3'd3, 32'd0);
        rreg(3'd2, d); check("R8", {32'd0, d}, 64'd1);
        rreg(3'd1, d); check("R5", {32'd0, d & 32'h2}, 64'h2);
        wreg(3'd1, 32'h2);
        rreg(3'd1, d); check("R5", {32'd0, d & 32'h2}, 64'h2);

        // R5 boundary with frozen time
        wreg(3'd3, 32'd1);                 // target = 0x1_0000_0001
        wreg(3'd1, 32'h2);
        rreg(3'd1, d); check("R4", {32'd0, d & 32'h2}, 64'h0);
        advance = 1'b0;
        t = 64'h1_0000_0001;
        sys_time = t - 64'd1;
        repeat (3) cyc();
        rreg(3'd1, d); check("R5", {32'd0, d & 32'h2}, 64'h0);
        sys_time = t;
        cyc();
        rreg(3'd1, d); check("R5", {32'd0, d & 32'h2}, 64'h2);
        sys_time = t + 64'd100;
        wreg(3'd1, 32'h2);
        rreg(3'd1, d); check("R10", {32'd0, d & 32'h2}, 64'h2);
        wreg(3'd2, 32'hFFFF_FFFF); wreg(3'd3, 32'hFFFF_FFFF);
        wreg(3'd1, 32'h2);
        rreg(3'd1, d); check("R4", {32'd0, d & 32'h2}, 64'h0);
        advance = 1'b1;

        // R2 slave capture across a low-word carry
        sys_time = 64'h5_FFFF_FFFE;
        s = sys_time;
        aux_slave = 1'b1;
        repeat (3) cyc();
        aux_slave = 1'b0;
        x = s + 64'd2;
        rreg(3'd4, d); check("R2", {32'd0, d}, {32'd0, x[31:0]});
        rreg(3'd5, d); check("R2", {32'd0, d}, {32'd0, x[63:32]});
        rreg(3'd1, d); check("R2", {32'd0, d & 32'hC}, 64'h4);

        // R3 no overwrite while held
        repeat (2) cyc();
        aux_slave = 1'b1;
        repeat (4) cyc();
        rreg(3'd4, d); check("R3", {32'd0, d}, {32'd0, x[31:0]});
        rreg(3'd5, d); check("R3", {32'd0, d}, {32'd0, x[63:32]});

        // R4 write-zero keeps, write-one clears
        wreg(3'd1, 32'h0);
        rreg(3'd1, d); check("R4", {32'd0, d & 32'h4}, 64'h4);
        wreg(3'd1, 32'h4);
        rreg(3'd1, d); check("R4", {32'd0, d & 32'h4}, 64'h0);

        // R9 level and falling edge capture nothing
        repeat (4) cyc();
        rreg(3'd1, d); check("R9", {32'd0, d & 32'h4}, 64'h0);
        aux_slave = 1'b0;
        repeat (4) cyc();
        rreg(3'd1, d); check("R9", {32'd0, d & 32'h4}, 64'h0);

        // R2 master capture
        s = sys_time;
        aux_master = 1'b1;
        repeat (3) cyc();
        aux_master = 1'b0;
        x = s + 64'd2;
        rreg(3'd6, d); check("R2", {32'd0, d}, {32'd0, x[31:0]});
        rreg(3'd7, d); check("R2", {32'd0, d}, {32'd0, x[63:32]});
        rreg(3'd1, d); check("R2", {32'd0, d & 32'hC}, 64'h8);

        // R10 ack in the capture cycle loses the edge
        s = sys_time;
        aux_slave = 1'b1;
        repeat (3) cyc();
        aux_slave = 1'b0;
        x = s + 64'd2;
        repeat (2) cyc();
        aux_slave = 1'b1;
        cyc(); cyc();
        wreg(3'd1, 32'h4);
        rreg(3'd1, d); check("R10", {32'd0, d & 32'h4}, 64'h0);
        rreg(3'd4, d); check("R10", {32'd0, d}, {32'd0, x[31:0]});

        // R6 pulse-per-second
        pps_tick = 1'b1; cyc(); pps_tick = 1'b0;
        rreg(3'd1, d); check("R6", {32'd0, d & 32'h10}, 64'h10);

        // R7 masks and interrupt
        check("R7", {63'd0, irq}, 64'd0);
        wreg(3'd0, 32'hFFFF_FFFF);
        rreg(3'd0, d); check("R7", {32'd0, d}, 64'h1E);
        check("R7", {63'd0, irq}, 64'd1);
        wreg(3'd0, 32'h4);
        check("R7", {63'd0, irq}, 64'd0);
        wreg(3'd0, 32'h10);
        check("R7", {63'd0, irq}, 64'd1);
        wreg(3'd1, 32'h1E);
        rreg(3'd1, d); check("R4", {32'd0, d}, 64'h0);
        check("R7", {63'd0, irq}, 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule